// File: doc/BRIEF.md
# Triggered and Synchronized Capture Timer Pair

This block holds two capture timers, an even one and an odd one. Each has a free-running counter and a small control register. Each timer runs in one of two modes. In synchronization mode a chosen source line clears the counter, which then keeps counting. In trigger mode the counter is held at zero until the chosen source arms it. An armed flag records that event, and software can also set or clear the flag. The source line is picked by a 5-bit code out of a 32-line source vector.

When both timers have their chaining flag set, they form one wide timer. The even counter is the low half and the odd counter is the high half. The even timer's mode and source govern the pair. A rising edge on a capture input latches the running count and raises a one-cycle valid strobe.

Capture results are strobes with no ready signal, so they cannot be held back. A consumer must take the data in the cycle the strobe is high. The data stays on the output until the next capture on that timer. The register port is a plain write strobe with a combinational read.

Top module: `cap_timer_pair`

## Requirements
- R1: After reset both control registers read 0x000D: source code 13, synchronization mode, flag clear, chaining off. Both capture valid bits are low.
- R2: The register layout is: bits [4:0] source code, bit 5 trigger mode (1) or synchronization mode (0), bit 6 armed flag, bit 7 chaining flag. Bits [15:8] always read zero. Address 0 is the even timer and address 1 is the odd timer. A write is visible on the read port in the cycle after its clock edge.
- R3: In synchronization mode with no active source, the counter increases by one on every clock edge.
- R4: In synchronization mode, an active selected source at an edge makes the counter zero after that edge. Counting resumes on the following edge.
- R5: In trigger mode with the armed flag clear, the counter is held at zero. An active selected source at an edge sets the flag, and the counter counts up from the next edge. Further source activity while the flag is set does not restart the count.
- R6: Software can write the armed flag. Clearing it holds the counter at zero from the next edge. Setting it starts the count. If a write clears the flag at the same edge as a hardware arm, the flag ends up set.
- R7: Each timer ignores its own code (2 for even, 3 for odd) as a source in both modes. Any other timer's code is a valid source.
- R8: Codes 30 and 31 are inactive in synchronization mode and active in trigger mode.
- R9: Chaining is active only when both chaining flags are set. The odd counter then steps when the even counter steps from its maximum value. The even timer's mode, flag and source hold or clear both counters.
- R10: A rising edge on a capture input at a clock edge latches the count that the counter held before that edge. The matching valid bit is high for exactly the next cycle, and the data holds until the next capture.
- R11: While chained, the even capture input latches both halves and raises only valid bit 0. The odd capture input is ignored and valid bit 1 stays low.
- R12: A counter that is not chained wraps from its maximum value to zero and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 even, 1 odd |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Selected register contents |
| src_i | input | 32 | Synchronization/trigger source lines |
| cap_in_i | input | 2 | Capture inputs, bit 0 even, bit 1 odd |
| cap_valid_o | output | 2 | One-cycle capture strobes |
| cap_even_o | output | CNT_W | Captured even count (low half when chained) |
| cap_odd_o | output | CNT_W | Captured odd count (high half when chained) |

## Verification
A source or arm event at edge E means the capture taken at edge E+k returns k-1. This holds in both modes, because the counter is zero after E and steps from E+1 on. The bench records the index of every event edge and computes each expected capture from that offset alone. The modulus of the counter width is applied, and when the timers are chained the result is split into halves. Captures and register reads are sampled at the falling edge one cycle after the edge that produced them. Capture edges are spaced at least two cycles apart so that the input is low again before each new rising edge.

// File: rtl/cap_pair_pkg.sv
package cap_pair_pkg;
  localparam int SEL_W    = 5;
  localparam int NSRC     = 1 << SEL_W;
  localparam int REG_W    = 16;
  localparam int MODE_BIT = SEL_W;
  localparam int STAT_BIT = SEL_W + 1;
  localparam int CASC_BIT = SEL_W + 2;
  localparam int CTL_W    = CASC_BIT + 1;
  localparam logic [SEL_W-1:0] SEL_RST = SEL_W'(13);

  // packed order matches the register bit positions
  typedef struct packed {
    logic             casc;
    logic             stat;
    logic             trig_mode;
    logic [SEL_W-1:0] sel;
  } ctl_t;
endpackage

// File: rtl/cap_ctl_reg.sv
module cap_ctl_reg
  import cap_pair_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             hw_set_i,
  output ctl_t             ctl_o,
  output logic [REG_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= '{casc: 1'b0, stat: 1'b0, trig_mode: 1'b0, sel: SEL_RST};
    end else begin
      if (wr_i) ctl_o <= ctl_t'(wdata_i);
      // hardware arming wins over a same-cycle software clear
      if (hw_set_i) ctl_o.stat <= 1'b1;
    end
  end

  assign rdata_o = {{(REG_W-CTL_W){1'b0}}, ctl_o};
endmodule

// File: rtl/cap_src_pick.sv
module cap_src_pick
  import cap_pair_pkg::*;
#(
  parameter int SELF_CODE    = 2,
  parameter int TRIG_ONLY_LO = 30
) (
  input  logic [NSRC-1:0]  src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             trig_mode_i,
  output logic             hit_o
);
  localparam logic [SEL_W-1:0] SELF_SEL = SEL_W'(SELF_CODE);

  logic line_w, allowed_w;
  assign line_w    = src_i[sel_i];
  assign allowed_w = (sel_i != SELF_SEL) &&
                     (trig_mode_i || (int'(sel_i) < TRIG_ONLY_LO));
  assign hit_o     = line_w & allowed_w;
endmodule

// File: rtl/cap_count.sv
module cap_count #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         carry_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (hold_i || clr_i) cnt_o <= '0;
    else if (step_i)          cnt_o <= cnt_o + 1'b1;
  end

  assign carry_o = step_i & ~hold_i & ~clr_i & (&cnt_o);
endmodule

// File: rtl/cap_grab.sv
module cap_grab #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lvl_i,
  input  logic         take_i,
  input  logic         show_i,
  input  logic [W-1:0] data_i,
  output logic         rise_o,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic prev_q;

  assign rise_o = lvl_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      prev_q  <= lvl_i;
      valid_o <= take_i & show_i;
      if (take_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/cap_timer_pair.sv
module cap_timer_pair
  import cap_pair_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int EVEN_SELF    = 2,
  parameter int ODD_SELF     = 3,
  parameter int TRIG_ONLY_LO = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic [NSRC-1:0]  src_i,
  input  logic [1:0]       cap_in_i,
  output logic [1:0]       cap_valid_o,
  output logic [CNT_W-1:0] cap_even_o,
  output logic [CNT_W-1:0] cap_odd_o
);
  ctl_t             ctl_w [2];
  logic [REG_W-1:0] rd_w  [2];
  logic [SEL_W-1:0] sel_w [2];
  logic [CNT_W-1:0] cnt_w [2];
  logic [CNT_W-1:0] cap_w [2];
  logic [1:0] mode_w, stat_w, hit_w, arm_w;
  logic [1:0] hold_own, clr_own, hold_w, clr_w, step_w, carry_w;
  logic [1:0] rise_w, take_w, show_w;
  logic       casc_w;
  logic       unused_w;

  assign unused_w = ^{reg_wdata_i[REG_W-1:CTL_W], carry_w[1]};

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    localparam int SELF = (g == 0) ? EVEN_SELF : ODD_SELF;

    cap_ctl_reg u_ctl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_we_i && (reg_addr_i == 1'(g))),
      .wdata_i (reg_wdata_i[CTL_W-1:0]),
      .hw_set_i(arm_w[g]),
      .ctl_o   (ctl_w[g]),
      .rdata_o (rd_w[g])
    );

    assign mode_w[g] = ctl_w[g].trig_mode;
    assign stat_w[g] = ctl_w[g].stat;
    assign sel_w[g]  = ctl_w[g].sel;

    cap_src_pick #(.SELF_CODE(SELF), .TRIG_ONLY_LO(TRIG_ONLY_LO)) u_pick (
      .src_i      (src_i),
      .sel_i      (sel_w[g]),
      .trig_mode_i(mode_w[g]),
      .hit_o      (hit_w[g])
    );

    assign arm_w[g]    = hit_w[g] & mode_w[g];
    assign hold_own[g] = mode_w[g] & ~stat_w[g];
    assign clr_own[g]  = ~mode_w[g] & hit_w[g];

    cap_count #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hold_i (hold_w[g]),
      .clr_i  (clr_w[g]),
      .step_i (step_w[g]),
      .cnt_o  (cnt_w[g]),
      .carry_o(carry_w[g])
    );

    cap_grab #(.W(CNT_W)) u_grab (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (cap_in_i[g]),
      .take_i (take_w[g]),
      .show_i (show_w[g]),
      .data_i (cnt_w[g]),
      .rise_o (rise_w[g]),
      .valid_o(cap_valid_o[g]),
      .data_o (cap_w[g])
    );
  end

  assign casc_w = ctl_w[0].casc & ctl_w[1].casc;

  // chaining: even control governs both counters, odd steps on even carry
  always_comb begin
    hold_w[0] = hold_own[0];
    clr_w[0]  = clr_own[0];
    step_w[0] = 1'b1;
    take_w[0] = rise_w[0];
    show_w[0] = 1'b1;
    if (casc_w) begin
      hold_w[1] = hold_own[0];
      clr_w[1]  = clr_own[0];
      step_w[1] = carry_w[0];
      take_w[1] = rise_w[0];
      show_w[1] = 1'b0;
    end else begin
      hold_w[1] = hold_own[1];
      clr_w[1]  = clr_own[1];
      step_w[1] = 1'b1;
      take_w[1] = rise_w[1];
      show_w[1] = 1'b1;
    end
  end

  assign reg_rdata_o = reg_addr_i ? rd_w[1] : rd_w[0];
  assign cap_even_o  = cap_w[0];
  assign cap_odd_o   = cap_w[1];
endmodule

// File: rtl/cap_timer_pair_chk.sv
module cap_timer_pair_chk
  import cap_pair_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int EVEN_SELF    = 2,
  parameter int TRIG_ONLY_LO = 30
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] rdata_i,
  input logic [NSRC-1:0]  src_i,
  input logic [1:0]       valid_i,
  input logic             casc_i,
  input logic             mode_i,
  input logic             stat_i,
  input logic [SEL_W-1:0] sel_i,
  input logic [CNT_W-1:0] cnt0_i,
  input logic [CNT_W-1:0] cnt1_i
);
  logic hit0, runs0;
  assign hit0  = src_i[sel_i] && (int'(sel_i) != EVEN_SELF) &&
                 (mode_i || (int'(sel_i) < TRIG_ONLY_LO));
  assign runs0 = (mode_i && stat_i) || (!mode_i && !hit0);

  assert_rd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_i[REG_W-1:CTL_W] == '0);

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    runs0 |=> cnt0_i == CNT_W'($past(cnt0_i) + 1'b1));

  assert_sync_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && hit0) |=> cnt0_i == '0);

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !stat_i) |=> cnt0_i == '0);

  assert_arm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && hit0) |=> stat_i);

  assert_carry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc_i && runs0 && (&cnt0_i)) |=> cnt1_i == CNT_W'($past(cnt1_i) + 1'b1));

  assert_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i[0] |=> !valid_i[0]);

  assert_odd_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_i |=> !valid_i[1]);
endmodule

bind cap_timer_pair cap_timer_pair_chk #(
  .CNT_W(CNT_W), .EVEN_SELF(EVEN_SELF), .TRIG_ONLY_LO(TRIG_ONLY_LO)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rdata_i(reg_rdata_o),
  .src_i  (src_i),
  .valid_i(cap_valid_o),
  .casc_i (casc_w),
  .mode_i (mode_w[0]),
  .stat_i (stat_w[0]),
  .sel_i  (sel_w[0]),
  .cnt0_i (cnt_w[0]),
  .cnt1_i (cnt_w[1])
);

// File: tb/cap_timer_pair_bench.sv
module cap_timer_pair_bench;
  import cap_pair_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int MAXV = 1 << W;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, addr = 1'b0;
  logic [REG_W-1:0] wdata = '0, rdata;
  logic [NSRC-1:0] src = '0;
  logic [1:0] cap_in = '0, vld;
  logic [W-1:0] ce, co;
  int ncyc = 0, checks = 0, errors = 0;
  bit done = 1'b0;

  cap_timer_pair #(.CNT_W(W)) u_cap_timer_pair (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_i(src),
    .cap_in_i(cap_in), .cap_valid_o(vld), .cap_even_o(ce), .cap_odd_o(co)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    if (ncyc > n) chk("bench schedule", ncyc, n);
    while (ncyc < n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [15:0] d, input int code, output int e);
    addr = a; wdata = d; we = 1'b1;
    if (code >= 0) src[code] = 1'b1;
    @(negedge clk);
    we = 1'b0; src = '0; e = ncyc;
  endtask

  task automatic rd(input logic a, input int exp, input string tag);
    addr = a; #1;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic pulse(input int code, output int e);
    src[code] = 1'b1;
    @(negedge clk);
    src = '0; e = ncyc;
  endtask

  // capture edge lands on clock edge number 'at'
  task automatic cap(input int at, input logic [1:0] raise, input logic [1:0] ev,
                     input int exp_e, input int exp_o, input string tag);
    wait_to(at - 1);
    cap_in = raise;
    @(negedge clk);
    chk({tag, " valid"}, int'(vld), int'(ev));
    if (exp_e >= 0) chk({tag, " even"}, int'(ce), exp_e);
    if (exp_o >= 0) chk({tag, " odd"}, int'(co), exp_o);
    cap_in = '0;
  endtask

  task automatic ignore_code(input int code, input string tag);
    int b, e;
    wr(1'b0, 16'h000D, -1, e);
    wr(1'b1, 16'h000D, -1, e);
    pulse(13, b);
    wr(1'b0, 16'(code), -1, e);
    wait_to(b + 5);
    pulse(code, e);
    cap(b + 12, 2'b11, 2'b11, 11, 11, tag);
  endtask

  initial begin
    int b, e, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1'b0, 16'h000D, "R1 even reg");
    rd(1'b1, 16'h000D, "R1 odd reg");
    chk("R1 valid", int'(vld), 0);
    // R2 layout and unused bits
    wr(1'b0, 16'hFFFF, -1, e);
    rd(1'b0, 16'h00FF, "R2 all ones");
    wr(1'b0, 16'h000D, -1, e);
    rd(1'b0, 16'h000D, "R2 readback");
    // R3 R4 R12 free-running sweep past wrap, both timers
    pulse(13, b);
    for (int k = 2; k <= 600; k += 7)
      cap(b + k, 2'b11, 2'b11, (k - 1) % MAXV, (k - 1) % MAXV, "R3 R12 count");
    // R4 second clear, R10 one-cycle strobe with held data
    pulse(13, b);
    cap(b + 2, 2'b01, 2'b01, 1, -1, "R4 clear");
    @(negedge clk);
    chk("R10 strobe drops", int'(vld), 0);
    chk("R10 data held", int'(ce), 1);
    cap(b + 5, 2'b01, 2'b01, 4, -1, "R4 resume");
    // R7 own code ignored, R8 trigger-only code ignored in sync mode
    ignore_code(EVEN_SELF_CODE, "R7 own code");
    ignore_code(30, "R8 sync ignores");
    // R7 other timer's code is a valid source
    wr(1'b0, 16'h000D, -1, e);
    pulse(13, b);
    wr(1'b0, 16'h0003, -1, e);
    wait_to(b + 5);
    pulse(3, e);
    cap(b + 12, 2'b11, 2'b11, b + 12 - e - 1, 11, "R7 other code");
    // R5 R8 trigger mode with a trigger-only code
    wr(1'b0, 16'h003E, -1, w);
    cap(w + 4, 2'b01, 2'b01, 0, -1, "R5 held");
    rd(1'b0, 16'h003E, "R5 flag clear");
    pulse(30, b);
    rd(1'b0, 16'h007E, "R5 R8 armed");
    cap(b + 5, 2'b01, 2'b01, 4, -1, "R8 trigger arms");
    cap(b + 300, 2'b01, 2'b01, 299 % MAXV, -1, "R5 counting");
    // R6 software flag control
    wr(1'b0, 16'h003E, -1, w);
    cap(w + 3, 2'b01, 2'b01, 0, -1, "R6 clear holds");
    wr(1'b0, 16'h007E, -1, w);
    cap(w + 5, 2'b01, 2'b01, 4, -1, "R6 set starts");
    wait_to(w + 8);
    pulse(30, e);
    cap(w + 12, 2'b01, 2'b01, 11, -1, "R5 no restart");
    wr(1'b0, 16'h003E, 30, w);
    rd(1'b0, 16'h007E, "R6 hardware wins");
    // R9 one chaining flag only: timers stay separate
    wr(1'b0, 16'h008D, -1, e);
    wr(1'b1, 16'h000D, -1, e);
    pulse(13, b);
    cap(b + 300, 2'b11, 2'b11, 299 % MAXV, 299 % MAXV, "R9 single flag");
    // R9 R11 chained sweep
    wr(1'b1, 16'h008D, -1, e);
    pulse(13, b);
    for (int k = 3; k <= 700; k += 23)
      cap(b + k, 2'b11, 2'b01, (k - 1) % MAXV, (k - 1) / MAXV, "R9 R11 chained");
    // R9 chained trigger mode governed by even control
    wr(1'b0, 16'h00AD, -1, w);
    cap(w + 4, 2'b11, 2'b01, 0, 0, "R9 chained held");
    pulse(13, b);
    cap(b + 260, 2'b11, 2'b01, 259 % MAXV, 259 / MAXV, "R9 chained trigger");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam int EVEN_SELF_CODE = 2;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule